// File: doc/BRIEF.md
# Indirect Test Register Access Bridge

This block lets a narrow 16-bit management register port reach a bank of up to 32 internal test and configuration registers. The internal registers have different widths, from 8 to 32 bits. Software never addresses a bank register directly. It first loads a 32-bit value into two write-data holding registers, one for the low half and one for the high half. It then writes a control word. That word holds a test-mode enable, a read index, a write index and two one-shot strobes: one starts a bank read and one starts a bank write.

A read strobe copies the selected bank register into two read-only result registers. One holds the low half and one holds the high half. Each result register is 16 bits wide. Narrow targets return zero in the high half. The result registers keep their contents until the next accepted read strobe. The strobes are never stored. Each acts on the same clock edge that writes the control word, and the control word always reads back with both strobe bits clear. Strobes are accepted only when the enable bit of that same written word is 1.

Top module: `indirect_test_bridge`

## Requirements
- R1: After reset, the control word, both write-data registers and both result registers read as 0.
- R2: The control word sits at management address 20. Its fields are: bit 10 = test enable, bits 9:5 = read index, bits 4:0 = write index. A write stores these fields and reads them back unchanged. Bits 15:11 always read as 0.
- R3: Bit 14 of a control write is the write strobe. Together with bit 10 = 1, it loads bank register [bits 4:0] with {high write-data, low write-data}, truncated to that register's width.
- R4: Bit 15 of a control write is the read strobe. Together with bit 10 = 1, it latches bank register [bits 9:5] into the result registers (address 21 = low 16 bits, address 22 = upper bits). For a register of 16 bits or fewer, the value sits right-aligned in address 21 and address 22 reads 0.
- R5: For a register wider than 16 bits, address 22 holds bits 16 and up of the register, right-aligned, and address 21 holds bits 15:0.
- R6: Both strobe bits self-clear: the control word never reads back with bit 15 or bit 14 set.
- R7: A strobe written together with bit 10 = 0 changes neither the bank nor the result registers.
- R8: If both strobes are set in one control write, the bank write happens first, and the read latches the new value.
- R9: Bank indices from 24 to 31 are unused. They read as 0 and ignore writes.
- R10: The result registers keep their latched value when the bank register is written later. They change only on the next accepted read strobe.
- R11: Address 23 is the low write-data register and address 24 is the high write-data register. Both are read/write. Any other unmapped address reads 0. Read data is combinational from the address in the same cycle.
- R12: Bank register i is 8*((i mod 4)+1) bits wide, giving a repeating pattern of 8, 16, 24 and 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_addr | input | 5 | Management register address |
| mgmt_we | input | 1 | Management write enable |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data, combinational from mgmt_addr |

## Verification
A management write takes effect on the rising edge where mgmt_we is high. The stored register, the bank update and the result latch all land on that same edge, so every result is due one edge after the stimulus. Each task drives inputs after a falling edge and lets one rising edge pass. It then reads the combinational read data at the next falling edge, after a short settling delay. For the hold and ignore cases, the bench reads the result registers once more after the later bank write or the rejected strobe, with no read strobe in between.

// File: rtl/itb_pkg.sv
package itb_pkg;
    localparam int DATA_W   = 16;
    localparam int WIDE_W   = 32;
    localparam int ADDR_W   = 5;

    // management map
    localparam logic [ADDR_W-1:0] MA_CTRL  = 5'd20;
    localparam logic [ADDR_W-1:0] MA_RB_LO = 5'd21;
    localparam logic [ADDR_W-1:0] MA_RB_HI = 5'd22;
    localparam logic [ADDR_W-1:0] MA_WD_LO = 5'd23;
    localparam logic [ADDR_W-1:0] MA_WD_HI = 5'd24;

    // control word bit positions
    localparam int CB_RD_STB = 15;
    localparam int CB_WR_STB = 14;
    localparam int CB_TEN    = 10;

    typedef struct packed {
        logic              ten;
        logic [ADDR_W-1:0] rd_idx;
        logic [ADDR_W-1:0] wr_idx;
    } ctrl_t;

    // width of bank register idx: repeating 8/16/24/32
    function automatic int reg_width(input int idx);
        return 8 * ((idx % 4) + 1);
    endfunction
endpackage

// File: rtl/itb_ctrl_regs.sv
module itb_ctrl_regs
    import itb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic              mgmt_we,
    input  logic [DATA_W-1:0] mgmt_wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] wd_lo,
    output logic [DATA_W-1:0] wd_hi,
    output logic              rd_fire,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] rd_idx_now,
    output logic [ADDR_W-1:0] wr_idx_now
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] wlo;
        logic [DATA_W-1:0] whi;
    } state_t;

    state_t st_d, st_q;
    logic   ctrl_hit;

    always_comb begin
        st_d       = st_q;
        ctrl_hit   = mgmt_we && (mgmt_addr == MA_CTRL);
        rd_fire    = 1'b0;
        wr_fire    = 1'b0;
        rd_idx_now = mgmt_wdata[9:5];
        wr_idx_now = mgmt_wdata[4:0];
        if (ctrl_hit) begin
            st_d.ctrl.ten    = mgmt_wdata[CB_TEN];
            st_d.ctrl.rd_idx = mgmt_wdata[9:5];
            st_d.ctrl.wr_idx = mgmt_wdata[4:0];
            rd_fire          = mgmt_wdata[CB_RD_STB] && mgmt_wdata[CB_TEN];
            wr_fire          = mgmt_wdata[CB_WR_STB] && mgmt_wdata[CB_TEN];
        end
        if (mgmt_we && (mgmt_addr == MA_WD_LO)) st_d.wlo = mgmt_wdata;
        if (mgmt_we && (mgmt_addr == MA_WD_HI)) st_d.whi = mgmt_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl  = st_q.ctrl;
    assign wd_lo = st_q.wlo;
    assign wd_hi = st_q.whi;
endmodule

// File: rtl/itb_bank.sv
module itb_bank
    import itb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_USED = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [WIDE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [WIDE_W-1:0] rd_val
);
    // next-state view of every register, so a same-edge read sees the write
    logic [WIDE_W-1:0] nxt [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        if (g < NUM_USED) begin : g_reg
            localparam int W = (reg_width(g) > WIDE_W) ? WIDE_W : reg_width(g);
            logic [W-1:0] val_d, val_q;

            always_comb begin
                val_d = val_q;
                if (wr_en && (wr_idx == ADDR_W'(g))) val_d = wr_data[W-1:0];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= '0;
                else        val_q <= val_d;
            end

            assign nxt[g] = WIDE_W'(val_d);
        end else begin : g_none
            assign nxt[g] = '0;
        end
    end

    always_comb begin
        rd_val = '0;
        if (int'(rd_idx) < NUM_REGS) rd_val = nxt[rd_idx];
    end
endmodule

// File: rtl/itb_readback.sv
module itb_readback
    import itb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic [WIDE_W-1:0] rd_val,
    output logic [DATA_W-1:0] rb_lo,
    output logic [DATA_W-1:0] rb_hi
);
    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (rd_fire) begin
            rb_d.lo = rd_val[DATA_W-1:0];
            rb_d.hi = rd_val[WIDE_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign rb_lo = rb_q.lo;
    assign rb_hi = rb_q.hi;
endmodule

// File: rtl/indirect_test_bridge.sv
module indirect_test_bridge
    import itb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_USED = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  mgmt_addr,
    input  logic        mgmt_we,
    input  logic [15:0] mgmt_wdata,
    output logic [15:0] mgmt_rdata
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] wd_lo, wd_hi, rb_lo, rb_hi;
    logic              rd_fire, wr_fire;
    logic [ADDR_W-1:0] rd_idx_now, wr_idx_now;
    logic [WIDE_W-1:0] rd_val;

    itb_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mgmt_addr  (mgmt_addr),
        .mgmt_we    (mgmt_we),
        .mgmt_wdata (mgmt_wdata),
        .ctrl       (ctrl),
        .wd_lo      (wd_lo),
        .wd_hi      (wd_hi),
        .rd_fire    (rd_fire),
        .wr_fire    (wr_fire),
        .rd_idx_now (rd_idx_now),
        .wr_idx_now (wr_idx_now)
    );

    itb_bank #(.NUM_REGS(NUM_REGS), .NUM_USED(NUM_USED)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire),
        .wr_idx  (wr_idx_now),
        .wr_data ({wd_hi, wd_lo}),
        .rd_idx  (rd_idx_now),
        .rd_val  (rd_val)
    );

    itb_readback u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_fire (rd_fire),
        .rd_val  (rd_val),
        .rb_lo   (rb_lo),
        .rb_hi   (rb_hi)
    );

    always_comb begin
        mgmt_rdata = '0;
        unique case (mgmt_addr)
            MA_CTRL:  mgmt_rdata = {5'b0, ctrl.ten, ctrl.rd_idx, ctrl.wr_idx};
            MA_RB_LO: mgmt_rdata = rb_lo;
            MA_RB_HI: mgmt_rdata = rb_hi;
            MA_WD_LO: mgmt_rdata = wd_lo;
            MA_WD_HI: mgmt_rdata = wd_hi;
            default:  mgmt_rdata = '0;
        endcase
    end
endmodule

module itb_checker
    import itb_pkg::*;
#(
    parameter int NUM_USED = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  mgmt_addr,
    input logic        mgmt_we,
    input logic [15:0] mgmt_wdata,
    input logic [15:0] mgmt_rdata,
    input logic [15:0] rb_lo,
    input logic [15:0] rb_hi
);
    logic ctrl_wr, rd_acc;
    assign ctrl_wr = mgmt_we && (mgmt_addr == MA_CTRL);
    assign rd_acc  = ctrl_wr && mgmt_wdata[CB_RD_STB] && mgmt_wdata[CB_TEN];

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_addr == MA_CTRL) |-> (mgmt_rdata[15:11] == 5'b0)); // R6

    AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> ($stable(rb_lo) && $stable(rb_hi))); // R10

    AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && (reg_width(int'(mgmt_wdata[9:5])) <= 16)) |=> (rb_hi == 16'h0)); // R4

    AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && (int'(mgmt_wdata[9:5]) >= NUM_USED)) |=> (rb_lo == 16'h0 && rb_hi == 16'h0)); // R9

    AST_CTRL_FIELDS_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !(mgmt_we && mgmt_addr != MA_CTRL)) |=>
        ((mgmt_addr != MA_CTRL) || (mgmt_rdata[10:0] == $past(mgmt_wdata[10:0])))); // R2
endmodule

bind indirect_test_bridge itb_checker #(.NUM_USED(NUM_USED)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mgmt_addr  (mgmt_addr),
    .mgmt_we    (mgmt_we),
    .mgmt_wdata (mgmt_wdata),
    .mgmt_rdata (mgmt_rdata),
    .rb_lo      (rb_lo),
    .rb_hi      (rb_hi)
);

// File: tb/sim_indirect_test_bridge.sv
module sim_indirect_test_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic        mgmt_we = 1'b0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [4:0] A_CTRL = 5'd20, A_LO = 5'd21, A_HI = 5'd22,
                           A_WLO = 5'd23, A_WHI = 5'd24;

    always #2.5 clk = ~clk;

    indirect_test_bridge u0 (
        .clk(clk), .rst_n(rst_n), .mgmt_addr(mgmt_addr),
        .mgmt_we(mgmt_we), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata)
    );

    // R12 width mask, written from the requirement
    function automatic logic [31:0] mask_for(input int idx);
        int w;
        if (idx >= 24) return 32'h0;
        w = 8 * ((idx % 4) + 1);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mw(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        mgmt_addr = a; mgmt_we = 1'b1; mgmt_wdata = d;
        @(negedge clk);
        mgmt_we = 1'b0;
    endtask

    task automatic mr(input logic [4:0] a, output logic [15:0] d);
        mgmt_addr = a;
        #1;
        d = mgmt_rdata;
    endtask

    task automatic bank_write(input int idx, input logic [31:0] v);
        mw(A_WLO, v[15:0]);
        mw(A_WHI, v[31:16]);
        mw(A_CTRL, 16'h4400 | 16'(idx));
    endtask

    task automatic bank_read(input int idx, input string req, input logic [31:0] exp);
        logic [15:0] d;
        mw(A_CTRL, 16'h8400 | (16'(idx) << 5));
        mr(A_LO, d); check(req, d, exp[15:0]);
        mr(A_HI, d); check(req, d, exp[31:16]);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        mr(A_CTRL, d); check("R1", d, 16'h0);
        mr(A_LO, d);   check("R1", d, 16'h0);
        mr(A_HI, d);   check("R1", d, 16'h0);
        mr(A_WLO, d);  check("R1", d, 16'h0);
        mr(A_WHI, d);  check("R1", d, 16'h0);
    endtask

    task automatic t_ctrl_fields();
        logic [15:0] d;
        mw(A_CTRL, 16'h07FF);
        mr(A_CTRL, d); check("R2", d, 16'h07FF);
        mw(A_WLO, 16'hBEEF); mw(A_WHI, 16'hDEAD);
        mr(A_WLO, d); check("R11", d, 16'hBEEF);
        mr(A_WHI, d); check("R11", d, 16'hDEAD);
        mr(5'd5, d);  check("R11", d, 16'h0);
        // strobes with enable off, reserved bits set
        mw(A_CTRL, 16'hF863);
        mr(A_CTRL, d); check("R6", d, 16'h0063);
        // R7: reg 3 untouched, result regs unchanged
        mr(A_LO, d); check("R7", d, 16'h0);
        bank_read(3, "R7", 32'h0);
    endtask

    task automatic t_widths();
        for (int i = 0; i < 4; i++) begin
            bank_write(i, 32'hDEAD_BEEF);
            bank_read(i, (i < 2) ? "R4" : "R5", 32'hDEAD_BEEF & mask_for(i));
        end
        bank_write(13, 32'h1234_5678);
        bank_read(13, "R12", 32'h1234_5678 & mask_for(13));
        bank_write(3, 32'hDEAD_BEEF);
        bank_read(3, "R3", 32'hDEAD_BEEF);
    endtask

    task automatic t_unused();
        bank_write(30, 32'hFFFF_FFFF);
        bank_read(30, "R9", 32'h0);
    endtask

    task automatic t_hold();
        logic [15:0] d;
        bank_read(3, "R10", 32'hDEAD_BEEF);
        bank_write(3, 32'h1234_5678);
        mr(A_LO, d); check("R10", d, 16'hBEEF);
        mr(A_HI, d); check("R10", d, 16'hDEAD);
        bank_read(3, "R10", 32'h1234_5678);
    endtask

    task automatic t_both();
        logic [15:0] d;
        mw(A_WLO, 16'hF00D); mw(A_WHI, 16'hCAFE);
        mw(A_CTRL, 16'hC400 | (16'd7 << 5) | 16'd7);
        mr(A_LO, d); check("R8", d, 16'hF00D);
        mr(A_HI, d); check("R8", d, 16'hCAFE);
        mr(A_CTRL, d); check("R6", d, 16'h04E7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_fields();
        t_widths();
        t_unused();
        t_hold();
        t_both();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule